// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns one request per machine cycle from an 8-bit core into the pin activity of a multiplexed external bus. A machine cycle lasts a fixed number of oscillator ticks (15 by default). Each tick is one clock of `clk`. Every cycle raises the address latch strobe `ale`, whether or not the cycle reaches external memory. The core offers one request per cycle: an instruction fetch, a data read, a data write or a bus-port output write. The block accepts it on the last tick of the previous cycle. It then plays out the address phase, a released bus where one is needed, and the active-low strobe for the data phase.

Instruction addresses are 12 bits wide. The low byte goes out on the shared 8-bit bus, and the top nibble replaces the low four bits of port 2 while the address is valid. A separate static latch holds bus-port output data. That data therefore survives external code fetches: the latch appears on `bport_q` from the start of the cycle that wrote it. The latch also drives the bus during every cycle that makes no external access.

Top module: `mbus_seq`

## Requirements
- R1: `ale` is high on phases 0 to 3 of every machine cycle and low on phases 4 to 14, including idle cycles and cycles that make no external access.
- R2: A machine cycle is 15 ticks long, and `req_ready` is high only on phase 14. A request presented on that tick runs in the following cycle. The kind codes are 0 instruction fetch, 1 data read, 2 data write and 3 bus-port write.
- R3: In an external cycle the bus drives `req_addr[7:0]` with `bus_oe` high on phases 0 to 4. On an external fetch, `p2_lo` carries `req_addr[11:8]` on those phases. At all other times `p2_lo` follows `p2_port`.
- R4: In an external fetch or read, `bus_oe` is low from phase 5 to phase 14, so the bus is released for at least one tick before the strobe falls.
- R5: `psen_n` is low on phases 6 to 11 for a fetch only when `ext_rom` was high at acceptance. A fetch accepted with `ext_rom` low drives no strobe and returns no data.
- R6: `rd_n` is low on phases 6 to 12 of a data read, and `wr_n` is low on phases 6 to 12 of a data write. At most one of `psen_n`, `rd_n` and `wr_n` is low at any tick.
- R7: During a data write, `bus_out` carries `req_wdata` with `bus_oe` high on phases 5 to 13. The data is driven one tick before `wr_n` falls and one tick after it rises.
- R8: The bus is sampled at the end of phase 11 for a fetch and at the end of phase 12 for a read. `rd_valid` is high for the single following tick, and `rd_data` then holds the sampled byte.
- R9: A bus-port write loads `req_wdata` into `bport_q` at the start of its cycle. `bport_q` then holds through all later external cycles. Once the latch has been written, every non-external cycle drives it on the bus with `bus_oe` high.
- R10: While reset is held, `ale` and `bus_oe` are low, the three strobes are high, `rd_valid` and `req_ready` are low, and `bport_q` is zero.
- R11: Request inputs are ignored on every tick other than the `req_ready` tick. Changing them mid-cycle does not alter the current cycle's pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rom | input | 1 | High: instruction fetches go to external memory |
| req_valid | input | 1 | A request is offered for the next cycle |
| req_kind | input | 2 | Request kind code (see R2) |
| req_addr | input | 12 | Program or data address |
| req_wdata | input | 8 | Data for a data write or bus-port write |
| req_ready | output | 1 | Last tick of the cycle; the request is taken |
| rd_data | output | 8 | Byte sampled from the bus |
| rd_valid | output | 1 | One-tick pulse, `rd_data` is new |
| ale | output | 1 | Address latch strobe, high at start of cycle |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| bus_in | input | 8 | Bus pin input value |
| bus_out | output | 8 | Bus pin output value |
| bus_oe | output | 1 | Bus output enable |
| p2_port | input | 4 | Port 2 low-nibble data from the core |
| p2_lo | output | 4 | Port 2 low-nibble pins |
| bport_q | output | 8 | Static bus-port output latch |

## Verification
The bench runs every request kind with `ext_rom` at both levels, plus idle cycles. The bus model returns a correct byte only on the tick the design should sample and the bit inverse on every other tick. A one-tick slip in capture therefore shows up as a wrong `rd_data`. Bus-port writes are mixed with external fetches, reads and writes. This separates the static latch from the address and data that share the bus. Random request values are also driven between `req_ready` ticks, which shows whether any input leaks into a cycle already running.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [1:0] {
    K_FETCH  = 2'd0,
    K_DREAD  = 2'd1,
    K_DWRITE = 2'd2,
    K_PORTW  = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/mbus_rst_sync.sv
module mbus_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/mbus_phase_ctr.sv
module mbus_phase_ctr #(
  parameter int CYC_TICKS = 15,
  parameter int PW        = $clog2(CYC_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [PW-1:0] phase,
  output logic          last
);
  localparam logic [PW-1:0] LAST_PH = PW'(CYC_TICKS - 1);

  logic [PW-1:0] phase_d;

  assign last = (phase == LAST_PH);

  always_comb begin
    phase_d = phase;
    if (run) phase_d = last ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= LAST_PH;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/mbus_strobe_dec.sv
module mbus_strobe_dec
  import mbus_pkg::*;
#(
  parameter int PW         = 4,
  parameter int ALE_TICKS  = 4,
  parameter int PSEN_TICKS = 6,
  parameter int RW_TICKS   = 7
) (
  input  logic [PW-1:0] phase,
  input  logic          ext,
  input  xfer_kind_e    kind,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          drv_addr,
  output logic          drv_wdata,
  output logic          smp_fetch,
  output logic          smp_read
);
  localparam logic [PW-1:0] ALE_END   = PW'(ALE_TICKS);
  localparam logic [PW-1:0] STB_FIRST = PW'(ALE_TICKS + 2);
  localparam logic [PW-1:0] PS_LAST   = PW'(ALE_TICKS + 1 + PSEN_TICKS);
  localparam logic [PW-1:0] RW_LAST   = PW'(ALE_TICKS + 1 + RW_TICKS);
  localparam logic [PW-1:0] WD_FIRST  = PW'(ALE_TICKS + 1);
  localparam logic [PW-1:0] WD_LAST   = PW'(ALE_TICKS + 2 + RW_TICKS);

  logic in_ps, in_rw, in_wd;

  always_comb begin
    in_ps     = (phase >= STB_FIRST) && (phase <= PS_LAST);
    in_rw     = (phase >= STB_FIRST) && (phase <= RW_LAST);
    in_wd     = (phase >= WD_FIRST)  && (phase <= WD_LAST);
    ale       = (phase < ALE_END);
    drv_addr  = ext && (phase <= ALE_END);
    drv_wdata = ext && (kind == K_DWRITE) && in_wd;
    psen_n    = !(ext && (kind == K_FETCH)  && in_ps);
    rd_n      = !(ext && (kind == K_DREAD)  && in_rw);
    wr_n      = !(ext && (kind == K_DWRITE) && in_rw);
    smp_fetch = ext && (kind == K_FETCH) && (phase == PS_LAST);
    smp_read  = ext && (kind == K_DREAD) && (phase == RW_LAST);
  end
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int CYC_TICKS  = 15,
  parameter int ALE_TICKS  = 4,
  parameter int PSEN_TICKS = 6,
  parameter int RW_TICKS   = 7,
  parameter int AW         = 12,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_rom,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [AW-DW-1:0] p2_port,
  output logic [AW-DW-1:0] p2_lo,
  output logic [DW-1:0] bport_q
);
  localparam int PW = $clog2(CYC_TICKS);
  localparam int HW = AW - DW;

  logic          run;
  logic [PW-1:0] phase;
  logic          last;
  logic          accept;

  xfer_kind_e    kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic          ext_q, ext_d;
  logic [DW-1:0] bp_q, bp_d;
  logic          live_q, live_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic          rval_q, rval_d;

  logic drv_addr, drv_wdata, smp_fetch, smp_read;

  mbus_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (run)
  );

  mbus_phase_ctr #(.CYC_TICKS(CYC_TICKS), .PW(PW)) u_ctr (
    .clk   (clk),
    .rst_n (run),
    .run   (run),
    .phase (phase),
    .last  (last)
  );

  mbus_strobe_dec #(
    .PW(PW), .ALE_TICKS(ALE_TICKS), .PSEN_TICKS(PSEN_TICKS), .RW_TICKS(RW_TICKS)
  ) u_dec (
    .phase     (phase),
    .ext       (ext_q),
    .kind      (kind_q),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .drv_addr  (drv_addr),
    .drv_wdata (drv_wdata),
    .smp_fetch (smp_fetch),
    .smp_read  (smp_read)
  );

  assign accept    = run && last;
  assign req_ready = accept;

  always_comb begin
    kind_d = kind_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    ext_d  = ext_q;
    bp_d   = bp_q;
    live_d = live_q;
    if (accept) begin
      kind_d = xfer_kind_e'(req_kind);
      addr_d = req_addr;
      wdat_d = req_wdata;
      unique case (xfer_kind_e'(req_kind))
        K_FETCH:           ext_d = req_valid && ext_rom;
        K_DREAD, K_DWRITE: ext_d = req_valid;
        default:           ext_d = 1'b0;
      endcase
      if (req_valid && (xfer_kind_e'(req_kind) == K_PORTW)) begin
        bp_d   = req_wdata;
        live_d = 1'b1;
      end
    end
    rval_d = smp_fetch || smp_read;
    rdat_d = rval_d ? bus_in : rdat_q;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      kind_q <= K_FETCH;
      addr_q <= '0;
      wdat_q <= '0;
      ext_q  <= 1'b0;
      bp_q   <= '0;
      live_q <= 1'b0;
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      ext_q  <= ext_d;
      bp_q   <= bp_d;
      live_q <= live_d;
      rdat_q <= rdat_d;
      rval_q <= rval_d;
    end
  end

  always_comb begin
    bus_oe = drv_addr || drv_wdata || (!ext_q && live_q);
    if (drv_addr)       bus_out = addr_q[DW-1:0];
    else if (drv_wdata) bus_out = wdat_q;
    else                bus_out = bp_q;
    p2_lo = (drv_addr && (kind_q == K_FETCH)) ? addr_q[AW-1:DW] : p2_port;
  end

  assign rd_data  = rdat_q;
  assign rd_valid = rval_q;
  assign bport_q  = bp_q;

  if (HW < 1) begin : g_bad_width
    $error("address must be wider than data");
  end
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic bus_oe,
  input logic rd_valid
);
  assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_ale_opens_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> ale);

  assert_ale_quiet_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!psen_n, !rd_n, !wr_n}));

  assert_float_before_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(psen_n) || $fell(rd_n)) |-> $past(!bus_oe));

  assert_wdata_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(bus_oe));

  assert_wdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> bus_oe);

  assert_rvalid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind mbus_seq mbus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .bus_oe    (bus_oe),
  .rd_valid  (rd_valid)
);

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, ext_rom, req_valid;
  logic [1:0]  req_kind;
  logic [11:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rd_valid, ale, psen_n, rd_n, wr_n, bus_oe;
  logic [7:0]  rd_data, bus_in, bus_out, bport_q;
  logic [3:0]  p2_port, p2_lo;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [7:0] bp_m;
  bit live_m;

  mbus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ext_rom(ext_rom), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .p2_port(p2_port), .p2_lo(p2_lo), .bport_q(bport_q)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [1:0] k, input logic [11:0] a);
    if (k == 2'd0) return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    return ~a[7:0] + 8'd3;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One machine cycle; called at the negedge of the req_ready tick.
  task automatic run_cycle(input bit v, input logic [1:0] k, input logic [11:0] a,
                           input logic [7:0] wd, input bit ea);
    bit ext;
    logic [3:0] p2v;
    logic [7:0] good;
    req_valid = v; req_kind = k; req_addr = a; req_wdata = wd; ext_rom = ea;
    p2v = 4'($urandom); p2_port = p2v;
    ext = v && (k == 2'd1 || k == 2'd2 || (k == 2'd0 && ea));
    good = mem_byte(k, a);
    if (v && k == 2'd3) begin bp_m = wd; live_m = 1; end
    @(posedge clk);
    #1;
    // R11: scramble request inputs while the cycle runs
    req_valid = 1'($urandom); req_kind = 2'($urandom);
    req_addr = 12'($urandom); req_wdata = 8'($urandom); ext_rom = 1'($urandom);
    for (int p = 0; p < 15; p++) begin
      bit drva, drvw, oe_e, ps_e, rd_e, wr_e, rv_e;
      logic [7:0] bus_e;
      @(negedge clk);
      drva = ext && p <= 4;
      drvw = ext && k == 2'd2 && p >= 5 && p <= 13;
      oe_e = drva || drvw || (!ext && live_m);
      bus_e = drva ? a[7:0] : (drvw ? wd : bp_m);
      ps_e = ext && k == 2'd0 && p >= 6 && p <= 11;
      rd_e = ext && k == 2'd1 && p >= 6 && p <= 12;
      wr_e = ext && k == 2'd2 && p >= 6 && p <= 12;
      rv_e = ext && ((k == 2'd0 && p == 12) || (k == 2'd1 && p == 13));
      chk("R1", "ale", ale, (p < 4));
      chk("R2", "req_ready", req_ready, (p == 14));
      if (drva) begin
        chk("R3", "addr oe", bus_oe, 1);
        chk("R3", "addr bus", bus_out, a[7:0]);
      end else if (drvw) begin
        chk("R7", "wdata oe", bus_oe, 1);
        chk("R7", "wdata bus", bus_out, wd);
      end else if (ext) begin
        chk("R4", "released oe", bus_oe, 0);
      end else begin
        chk("R9", "latch oe", bus_oe, oe_e);
        if (oe_e) chk("R9", "latch bus", bus_out, bp_m);
      end
      chk("R3", "p2_lo", p2_lo, (drva && k == 2'd0) ? a[11:8] : p2v);
      chk("R5", "psen_n", psen_n, !ps_e);
      chk("R6", "rd_n", rd_n, !rd_e);
      chk("R6", "wr_n", wr_n, !wr_e);
      chk("R8", "rd_valid", rd_valid, rv_e);
      if (rv_e) chk("R8", "rd_data", rd_data, good);
      chk("R9 R11", "bport_q", bport_q, bp_m);
      // drive the right byte only on the sampling tick
      if ((k == 2'd0 && p == 11) || (k == 2'd1 && p == 12)) bus_in = good;
      else bus_in = ~good;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    bp_m = 8'h00; live_m = 0;
    rst_n = 0; ext_rom = 0; req_valid = 0; req_kind = 0; req_addr = 0;
    req_wdata = 0; bus_in = 8'hFF; p2_port = 4'h9;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "ale", ale, 0);
    chk("R10", "strobes", {psen_n, rd_n, wr_n}, 3'b111);
    chk("R10", "bus_oe", bus_oe, 0);
    chk("R10", "rd_valid", rd_valid, 0);
    chk("R10", "req_ready", req_ready, 0);
    chk("R10", "bport_q", bport_q, 0);
    rst_n = 1;
    for (int i = 0; i < 20 && !req_ready; i++) @(negedge clk);
    chk("R2", "first ready", req_ready, 1);
    // directed corners
    run_cycle(0, 2'd0, 12'h000, 8'h00, 1);   // idle cycle, R1
    run_cycle(1, 2'd0, 12'hFFF, 8'h00, 0);   // internal fetch, R5
    run_cycle(1, 2'd0, 12'hA5C, 8'h00, 1);   // external fetch
    run_cycle(1, 2'd3, 12'h123, 8'h3C, 1);   // bus-port write, R9
    run_cycle(1, 2'd0, 12'hFFF, 8'h00, 1);   // fetch keeps latch
    run_cycle(1, 2'd1, 12'h0FF, 8'h00, 0);   // read
    run_cycle(1, 2'd2, 12'h000, 8'hFF, 1);   // write, R7
    run_cycle(0, 2'd3, 12'h000, 8'h77, 1);   // invalid port write ignored
    run_cycle(1, 2'd3, 12'h000, 8'h00, 0);
    // random mix
    for (int n = 0; n < 400; n++)
      run_cycle(($urandom % 8) != 0, 2'($urandom), 12'($urandom), 8'($urandom),
                1'($urandom));
    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule